// File: doc/BRIEF.md
# Two-Operand NaN Propagation Unit

This unit decides what a binary32 floating-point operation returns when one or both of its two operands are NaN. It sorts each operand into quiet NaN, signaling NaN or ordinary value. It then chooses one operand under a selectable priority rule. If the chosen operand is signaling, it is turned into a quiet NaN before it is returned. It also raises an invalid-operation flag whenever a signaling NaN is present.

Two mode inputs adapt the unit to the surrounding datapath. One mode inverts the meaning of the top fraction bit, so that a set bit marks a signaling NaN. The other mode replaces every result with a fixed default NaN.

A parameter adds one register stage on the result and the flag. This stage has a valid input and a valid output. The caller must present at least one NaN operand. Results for two ordinary operands are not defined.

Top module: `nan_select_unit`

## Requirements
- R1: With `snan_one` low, an operand is a quiet NaN when bits 30..23 are all ones and bit 22 is set. It is a signaling NaN when bits 30..23 are all ones, bit 22 is clear and bits 21..0 are not all zero.
- R2: With `snan_one` high, the quiet and signaling tests of R1 swap roles.
- R3: `invalid` is 1 exactly when either operand is a signaling NaN under the active convention. This holds in default-NaN mode too.
- R4: With `dflt_mode` high, `result` is the default NaN. The default NaN is 0x7FC00000 when `snan_one` is low and 0x7FBFFFFF when `snan_one` is high.
- R5: Policy code 2'b00 takes the first match in this list: `op_a` if signaling, `op_b` if signaling, `op_a` if quiet, and otherwise `op_b`.
- R6: Policy code 2'b01 returns `op_a` whenever it is any NaN and otherwise returns `op_b`. Code 2'b11 behaves the same way.
- R7: Policy code 2'b10 follows three rules. When one operand is a signaling NaN and the other a quiet NaN, it returns the quiet one. When only one operand is a NaN, it returns that NaN. When both are NaNs of the same kind, it applies R8.
- R8: Under code 2'b10, two NaNs of the same kind are compared on bits 30..0, and the larger one wins. When bits 30..0 are equal, the operand with sign bit 0 wins, and if the signs also match `op_b` is returned.
- R9: A chosen signaling NaN is silenced before it is returned. With `snan_one` low, bit 22 is set and the other bits are kept. With `snan_one` high, the default NaN of R4 is returned.
- R10: With `REG_OUT`=1, `out_valid` follows `in_valid` one cycle later. `result` and `invalid` load only in a cycle where `in_valid` is high, and otherwise hold their value. Reset clears `out_valid`, `result` and `invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and modes are valid |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| policy | input | 2 | NaN priority rule select |
| snan_one | input | 1 | Inverted quiet-bit convention |
| dflt_mode | input | 1 | Force the default NaN as result |
| out_valid | output | 1 | Result and flag are valid |
| result | output | 32 | Propagated NaN |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Several properties are checked on every valid output by the assertions:
- the flag matches the signaling status of the captured operands;
- default-NaN mode gives the convention's default pattern;
- the result is always a NaN that is quiet under the active convention;
- code 01 passes `op_a` through when it is a quiet NaN;
- the valid output lags the valid input by one cycle.

The bench shows what the assertions cannot. It checks which operand each policy picks and how policy 10 breaks ties on magnitude and sign. It checks the exact silenced bit patterns, and that the outputs hold while `in_valid` is low. It does this by sweeping operand pairs against every policy code and mode combination.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

  typedef enum logic [1:0] {
    POL_ORDERED = 2'b00,
    POL_FIRST   = 2'b01,
    POL_MAG     = 2'b10,
    POL_RSVD    = 2'b11
  } nan_policy_e;

  typedef struct packed {
    logic quiet;
    logic signaling;
  } nan_kind_t;

endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  inv,
  output nan_kind_t             kind
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic exp_ones;
  logic top_bit;
  logic rest_nz;
  logic form_q;
  logic form_s;

  always_comb begin
    exp_ones  = &op[W-2:FRAC_W];
    top_bit   = op[FRAC_W-1];
    rest_nz   = |op[FRAC_W-2:0];
    form_q    = exp_ones & top_bit;
    form_s    = exp_ones & ~top_bit & rest_nz;
    kind.quiet     = inv ? form_s : form_q;
    kind.signaling = inv ? form_q : form_s;
  end

endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nanprop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  nan_kind_t    kind_a,
  input  nan_kind_t    kind_b,
  input  logic [1:0]   policy,
  output logic         pick_b
);
  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;
  logic         a_larger;

  always_comb begin
    mag_a    = op_a[W-2:0];
    mag_b    = op_b[W-2:0];
    a_larger = (mag_a > mag_b) |
               ((mag_a == mag_b) & ~op_a[W-1] & op_b[W-1]);

    unique case (nan_policy_e'(policy))
      POL_ORDERED: pick_b = ~kind_a.signaling &
                            (kind_b.signaling | ~kind_a.quiet);
      POL_MAG: begin
        if (kind_a.signaling)
          pick_b = kind_b.signaling ? ~a_larger : kind_b.quiet;
        else if (kind_a.quiet)
          pick_b = kind_b.quiet & ~a_larger;
        else
          pick_b = 1'b1;
      end
      default: pick_b = ~(kind_a.quiet | kind_a.signaling);
    endcase
  end

endmodule

// File: rtl/nan_quieten.sv
module nan_quieten #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] chosen,
  input  logic                  chosen_sig,
  input  logic                  inv,
  input  logic                  dflt_mode,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] DFLT_NORM =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DFLT_INV =
    {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic [W-1:0] dflt_nan;

  always_comb begin
    dflt_nan = inv ? DFLT_INV : DFLT_NORM;
    if (dflt_mode)
      result = dflt_nan;
    else if (chosen_sig && inv)
      result = dflt_nan;
    else if (chosen_sig)
      result = chosen | (W'(1) << (FRAC_W - 1));
    else
      result = chosen;
  end

endmodule

// File: rtl/nan_select_unit.sv
module nan_select_unit
  import nanprop_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic [1:0]            policy,
  input  logic                  snan_one,
  input  logic                  dflt_mode,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [W-1:0] ops [2];
  nan_kind_t    kinds [2];
  logic         pick_b;
  logic [W-1:0] chosen;
  logic         chosen_sig;
  logic [W-1:0] res_comb;
  logic         inv_comb;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op   (ops[k]),
      .inv  (snan_one),
      .kind (kinds[k])
    );
  end

  nan_pick #(.W(W)) u_pick (
    .op_a   (op_a),
    .op_b   (op_b),
    .kind_a (kinds[0]),
    .kind_b (kinds[1]),
    .policy (policy),
    .pick_b (pick_b)
  );

  always_comb begin
    chosen     = pick_b ? op_b : op_a;
    chosen_sig = pick_b ? kinds[1].signaling : kinds[0].signaling;
    inv_comb   = kinds[0].signaling | kinds[1].signaling;
  end

  nan_quieten #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .chosen     (chosen),
    .chosen_sig (chosen_sig),
    .inv        (snan_one),
    .dflt_mode  (dflt_mode),
    .result     (res_comb)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] res_d, res_q;
    logic         inv_d, inv_q;
    logic         vld_q;

    always_comb begin
      res_d = res_q;
      inv_d = inv_q;
      if (in_valid) begin
        res_d = res_comb;
        inv_d = inv_comb;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        inv_q <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        res_q <= res_d;
        inv_q <= inv_d;
        vld_q <= in_valid;
      end
    end

    assign result    = res_q;
    assign invalid   = inv_q;
    assign out_valid = vld_q;
  end else begin : g_comb
    assign result    = res_comb;
    assign invalid   = inv_comb;
    assign out_valid = in_valid;
  end

endmodule

// File: rtl/nan_select_unit_chk.sv
module nan_select_unit_chk #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic [1:0]            policy,
  input logic                  snan_one,
  input logic                  dflt_mode,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QTHRESH = {{(EXP_W+1){1'b1}}, {(FRAC_W){1'b0}}};
  localparam logic [W-1:0] INFMAG  = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [W-1:0] c_a, c_b;
  logic [1:0]   c_pol;
  logic         c_one, c_dflt;

  if (REG_OUT) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_a <= '0; c_b <= '0; c_pol <= '0; c_one <= 1'b0; c_dflt <= 1'b0;
      end else if (in_valid) begin
        c_a <= op_a; c_b <= op_b; c_pol <= policy;
        c_one <= snan_one; c_dflt <= dflt_mode;
      end
    end
  end else begin : g_cap
    assign c_a = op_a;
    assign c_b = op_b;
    assign c_pol = policy;
    assign c_one = snan_one;
    assign c_dflt = dflt_mode;
  end

  function automatic logic plain_quiet(logic [W-1:0] x);
    return {x[W-2:0], 1'b0} >= QTHRESH;
  endfunction
  function automatic logic any_nan(logic [W-1:0] x);
    return x[W-2:0] > INFMAG;
  endfunction
  function automatic logic is_sig(logic [W-1:0] x, logic one);
    return one ? plain_quiet(x) : (any_nan(x) && !plain_quiet(x));
  endfunction

  logic some_nan;
  assign some_nan = any_nan(c_a) | any_nan(c_b);

  assert_invalid_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> invalid == (is_sig(c_a, c_one) | is_sig(c_b, c_one)));

  assert_default_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_dflt) |->
      result == (c_one ? {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}}
                       : {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));

  assert_first_quiet_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_dflt && c_pol[0] && any_nan(c_a) && !is_sig(c_a, c_one))
      |-> result == c_a);

  assert_result_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && some_nan) |->
      (any_nan(result) && result[FRAC_W-1] == !c_one));

  if (REG_OUT) begin : g_lat
    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> out_valid == $past(in_valid));
  end

endmodule

bind nan_select_unit nan_select_unit_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .policy(policy), .snan_one(snan_one), .dflt_mode(dflt_mode),
  .out_valid(out_valid), .result(result), .invalid(invalid)
);

// File: tb/test_nan_select_unit.sv
`timescale 1ns/1ps
module test_nan_select_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic [1:0]  policy;
  logic        snan_one, dflt_mode;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nan_select_unit i_nan_select_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .policy(policy), .snan_one(snan_one), .dflt_mode(dflt_mode),
    .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  function automatic logic [31:0] pool(int i);
    case (i)
      0:  return 32'h3F80_0000;
      1:  return 32'hBF80_0000;
      2:  return 32'h7F80_0000;
      3:  return 32'h7FC0_0000;
      4:  return 32'hFFC0_0001;
      5:  return 32'h7FFF_FFFF;
      6:  return 32'h7FC0_0005;
      7:  return 32'h7F80_0001;
      8:  return 32'hFF80_0001;
      9:  return 32'h7FBF_FFFF;
      10: return 32'h7FA0_0000;
      default: return 32'hFFC0_0000;
    endcase
  endfunction

  function automatic bit nan_of(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit q_of(logic [31:0] x, bit one);
    bit pq = nan_of(x) && x[22];
    bit ps = nan_of(x) && !x[22];
    return one ? ps : pq;
  endfunction
  function automatic bit s_of(logic [31:0] x, bit one);
    return nan_of(x) && !q_of(x, one);
  endfunction

  // returns {invalid, result}
  function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b,
                                        logic [1:0] pol, bit one, bit dfl);
    logic [31:0] dn = one ? 32'h7FBF_FFFF : 32'h7FC0_0000;
    bit aq = q_of(a, one), as_ = s_of(a, one);
    bit bq = q_of(b, one), bs  = s_of(b, one);
    bit inv = as_ | bs;
    bit take_a;
    bit a_big;
    logic [31:0] r;
    if (a[30:0] != b[30:0]) a_big = a[30:0] > b[30:0];
    else a_big = (a[31] == 1'b0) && (b[31] == 1'b1);
    if (pol == 2'd0) begin
      if (as_) take_a = 1; else if (bs) take_a = 0;
      else if (aq) take_a = 1; else take_a = 0;
    end else if (pol == 2'd2) begin
      if (!(aq || as_)) take_a = 0;
      else if (!(bq || bs)) take_a = 1;
      else if (as_ && bq) take_a = 0;
      else if (aq && bs) take_a = 1;
      else take_a = a_big;
    end else begin
      take_a = aq || as_;
    end
    r = take_a ? a : b;
    if (dfl) r = dn;
    else if (s_of(r, one)) r = one ? dn : (r | 32'h0040_0000);
    return {inv, r};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic run1(string tag, logic [31:0] a, logic [31:0] b,
                      logic [1:0] pol, bit one, bit dfl);
    logic [32:0] e = model(a, b, pol, one, dfl);
    op_a = a; op_b = b; policy = pol; snan_one = one; dflt_mode = dfl;
    in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " result"}, result, e[31:0]);
    chk("R3 invalid", {31'b0, invalid}, {31'b0, e[32]});
    chk("R10 out_valid", {31'b0, out_valid}, 32'd1);
  endtask

  initial begin
    #(200_000 * 5.0);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    policy = '0; snan_one = 1'b0; dflt_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10 reset result", result, 32'd0);
    chk("R10 reset invalid", {31'b0, invalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed cases
    run1("R1 sNaN b picked and silenced", 32'h7FC0_0000, 32'h7F80_0001, 2'd0, 0, 0);
    chk("R1 value", result, 32'h7FC0_0001);
    run1("R2 inverted swaps kinds", 32'h7FC0_0000, 32'h7F80_0001, 2'd0, 1, 0);
    chk("R2 value", result, 32'h7FBF_FFFF);
    run1("R9 normal silence", 32'h7F80_0001, 32'h3F80_0000, 2'd1, 0, 0);
    chk("R9 value", result, 32'h7FC0_0001);
    run1("R8 tie positive wins", 32'hFFC0_0000, 32'h7FC0_0000, 2'd2, 0, 0);
    chk("R8 value", result, 32'h7FC0_0000);
    run1("R8 larger magnitude", 32'h7FC0_0010, 32'hFFC0_0001, 2'd2, 0, 0);
    chk("R8 value2", result, 32'h7FC0_0010);
    run1("R4 default with invalid", 32'h7F80_0001, 32'h7FC0_0000, 2'd0, 0, 1);
    chk("R4 value", result, 32'h7FC0_0000);
    chk("R3 flag in default mode", {31'b0, invalid}, 32'd1);
    run1("R6 reserved code", 32'h3F80_0000, 32'hFFC0_0001, 2'd3, 0, 0);
    chk("R6 value", result, 32'hFFC0_0001);

    // hold while in_valid is low
    in_valid = 1'b0; op_a = 32'h7F80_0001; op_b = 32'h7F80_0002; policy = 2'd0;
    @(negedge clk);
    chk("R10 hold result", result, 32'hFFC0_0001);
    chk("R10 hold invalid", {31'b0, invalid}, 32'd0);
    chk("R10 out_valid low", {31'b0, out_valid}, 32'd0);

    // sweep
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int p = 0; p < 4; p++)
          for (int m = 0; m < 4; m++) begin
            string tag;
            if (!nan_of(pool(i)) && !nan_of(pool(j))) continue;
            if (m[1]) tag = "R4";
            else if (p == 0) tag = "R5";
            else if (p == 2) tag = "R7";
            else tag = "R6";
            run1(tag, pool(i), pool(j), p[1:0], m[0], m[1]);
          end

    in_valid = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule